// File: doc/BRIEF.md
# Banked Output Channel Accumulator

This block holds the running partial sums of every output channel for one output pixel of a convolution layer. A set of parallel processing elements delivers one result per lane per cycle. Each result is tagged with the output channel it belongs to and with the input channel it came from. A result from input channel zero replaces the stored sum. Any later input channel adds its result to the stored sum through a read-modify-write.

The storage is interleaved over one bank per lane, so channel `co` lives in bank `co mod N_PE`. Each lane owns its bank, and all lanes update in the same cycle without conflict. Every bank has two ports and a two-cycle read latency. An update that meets an earlier update to the same entry, still in flight, takes its old value from the pending sum rather than from the array.

Once the last input channel has been folded in, a drain command streams every channel's sum out in ascending channel order over a valid/ready handshake. Each beat is paired with its flat, channel-major address in external memory. The pixel term of that address is computed once, when the drain starts, and held for the whole drain.

Top module: `out_ch_accum`

## Requirements
- R1: After reset, `drain_busy` and `drain_valid` are low.
- R2: An accepted update whose input channel index is zero sets the channel's sum to the update value, whatever was stored before.
- R3: An accepted update with a nonzero input channel index adds its value to the channel's stored sum. The write reaches the bank exactly two cycles after the update is accepted.
- R4: Lane `p` accepts only channels whose low log2(N_PE) bits equal `p`. An update that names another channel, or whose valid bit is low, changes no sum.
- R5: Updates to the same channel arriving one or two cycles apart are all counted; none is lost to the read latency.
- R6: Sums are two's complement DATA_W-bit values that wrap on overflow.
- R7: After `drain_start`, the block presents every channel exactly once, from 0 to NUM_CO-1. While `drain_valid` is high and `drain_ready` is low, the beat holds with its data and address unchanged. `drain_busy` falls after the last beat is taken.
- R8: The address of channel `co` is `co*chan_pixels + out_row*out_width + out_col`, modulo 2^ADDR_W. The coordinates are captured in the cycle that `drain_start` is taken.
- R9: `drain_valid` stays low while idle and for the first two cycles after a drain starts. Updates presented while `drain_busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | N_PE | Per-lane update valid |
| upd_co | input | N_PE*CO_W | Per-lane output channel index |
| upd_ci | input | N_PE*CI_W | Per-lane input channel index (zero means overwrite) |
| upd_val | input | N_PE*DATA_W | Per-lane signed partial result |
| drain_start | input | 1 | Starts a drain; ignored while busy |
| out_row | input | RC_W | Output row of the current pixel |
| out_col | input | RC_W | Output column of the current pixel |
| out_width | input | RC_W | Output image width |
| chan_pixels | input | ADDR_W | Pixels in one output channel plane |
| drain_busy | output | 1 | Drain in progress |
| drain_valid | output | 1 | Drain beat valid |
| drain_ready | input | 1 | Drain beat accepted |
| drain_data | output | DATA_W | Sum of the channel on the drain |
| drain_addr | output | ADDR_W | Flat external address of that sum |

## Verification
The bench goes after the hazards of the two-cycle read. It sends runs of updates to one channel in consecutive cycles and in alternating cycles. A design with missing or wrongly prioritised forwarding would drop increments, and its drained sums would fall short.

Large values force sums past the signed range, and addresses are chosen to exceed the address width, so any saturation or widening shows up on the ports. Updates that are misrouted, not valid, or sent during a drain are each followed by a drain that would expose a corrupted channel. A design that forgot the overwrite on input channel zero would carry the previous pixel's sums into the next one.

The drain is run with a stalling ready pattern. A beat that advanced or changed under back-pressure would skip or repeat a channel.

// File: rtl/oca_pkg.sv
package oca_pkg;

  typedef enum logic [1:0] {
    DR_IDLE,
    DR_ISSUE,
    DR_WAIT,
    DR_SHOW
  } drain_st_e;

  // Pixel term of the output address: row * width + column.
  function automatic logic [31:0] pixel_offset(input logic [31:0] row,
                                               input logic [31:0] width,
                                               input logic [31:0] col);
    return row * width + col;
  endfunction

  // Channel-major placement: channel plane base plus pixel term.
  function automatic logic [31:0] chan_major_addr(input logic [31:0] co,
                                                  input logic [31:0] chpix,
                                                  input logic [31:0] pix_off);
    return co * chpix + pix_off;
  endfunction

endpackage

// File: rtl/oca_bank.sv
module oca_bank #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic              upd_first,
  input  logic [DATA_W-1:0] upd_val,
  input  logic              drain_mode,
  input  logic [IDX_W-1:0]  drain_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              wr_en
);
  localparam int DEPTH = 1 << IDX_W;

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  rd_addr;
  logic [DATA_W-1:0] rd_q1, rd_q2;

  logic              s1_v, s2_v;
  logic [IDX_W-1:0]  s1_idx, s2_idx;
  logic              s1_first, s2_first;
  logic [DATA_W-1:0] s1_val, s2_val;

  logic              wb1_v, wb2_v;
  logic [IDX_W-1:0]  wb1_idx, wb2_idx;
  logic [DATA_W-1:0] wb1_d, wb2_d;

  logic              fwd_near, fwd_far;
  logic [DATA_W-1:0] old_val, wr_data;

  // Port A: reads for updates or for the drain.
  assign rd_addr = drain_mode ? drain_idx : upd_idx;

  // Two-cycle registered read, port B write.
  always_ff @(posedge clk) begin
    rd_q1 <= mem[rd_addr];
    rd_q2 <= rd_q1;
    if (wr_en) mem[s2_idx] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s2_v  <= 1'b0;
      wb1_v <= 1'b0;
      wb2_v <= 1'b0;
    end else begin
      s1_v  <= upd_valid;
      s2_v  <= s1_v;
      wb1_v <= wr_en;
      wb2_v <= wb1_v;
    end
  end

  always_ff @(posedge clk) begin
    s1_idx   <= upd_idx;
    s1_first <= upd_first;
    s1_val   <= upd_val;
    s2_idx   <= s1_idx;
    s2_first <= s1_first;
    s2_val   <= s1_val;
    wb1_idx  <= s2_idx;
    wb1_d    <= wr_data;
    wb2_idx  <= wb1_idx;
    wb2_d    <= wb1_d;
  end

  // Writes one or two cycles older were not visible to this read.
  assign fwd_near = wb1_v && (wb1_idx == s2_idx);
  assign fwd_far  = wb2_v && (wb2_idx == s2_idx);

  always_comb begin
    if (fwd_near)     old_val = wb1_d;
    else if (fwd_far) old_val = wb2_d;
    else              old_val = rd_q2;
  end

  assign wr_en   = s2_v;
  assign wr_data = s2_first ? s2_val : wrap_add(old_val, s2_val);
  assign rd_data = rd_q2;

endmodule

// File: rtl/oca_drain.sv
module oca_drain
  import oca_pkg::*;
#(
  parameter int NUM_CO = 16,
  parameter int CO_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            ready,
  output logic            busy,
  output logic            valid,
  output logic [CO_W-1:0] co
);
  localparam logic [CO_W-1:0] LAST_CO = CO_W'(NUM_CO - 1);

  drain_st_e       st;
  logic [CO_W-1:0] co_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= DR_IDLE;
      co_q <= '0;
    end else begin
      unique case (st)
        DR_IDLE: if (start) begin
          co_q <= '0;
          st   <= DR_ISSUE;
        end
        DR_ISSUE: st <= DR_WAIT;
        DR_WAIT:  st <= DR_SHOW;
        DR_SHOW: if (ready) begin
          if (co_q == LAST_CO) begin
            st <= DR_IDLE;
          end else begin
            co_q <= co_q + 1'b1;
            st   <= DR_ISSUE;
          end
        end
        default: st <= DR_IDLE;
      endcase
    end
  end

  assign busy  = (st != DR_IDLE);
  assign valid = (st == DR_SHOW);
  assign co    = co_q;

endmodule

// File: rtl/oca_addr.sv
module oca_addr
  import oca_pkg::*;
#(
  parameter int RC_W   = 8,
  parameter int ADDR_W = 16,
  parameter int CO_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [RC_W-1:0]   row,
  input  logic [RC_W-1:0]   col,
  input  logic [RC_W-1:0]   width,
  input  logic [ADDR_W-1:0] chpix,
  input  logic [CO_W-1:0]   co,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] pix_off_q;
  logic [ADDR_W-1:0] chpix_q;
  logic [31:0]       full_addr;

  // The pixel term is formed once per drain and then held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_off_q <= '0;
      chpix_q   <= '0;
    end else if (load) begin
      pix_off_q <= ADDR_W'(pixel_offset(32'(row), 32'(width), 32'(col)));
      chpix_q   <= chpix;
    end
  end

  assign full_addr = chan_major_addr(32'(co), 32'(chpix_q), 32'(pix_off_q));
  assign addr      = full_addr[ADDR_W-1:0];

endmodule

// File: rtl/out_ch_accum.sv
module out_ch_accum #(
  parameter int N_PE   = 4,
  parameter int NUM_CO = 16,
  parameter int DATA_W = 16,
  parameter int CI_W   = 4,
  parameter int RC_W   = 8,
  parameter int ADDR_W = 16,
  localparam int CO_W  = $clog2(NUM_CO)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_PE-1:0]        upd_valid,
  input  logic [N_PE*CO_W-1:0]   upd_co,
  input  logic [N_PE*CI_W-1:0]   upd_ci,
  input  logic [N_PE*DATA_W-1:0] upd_val,
  input  logic                   drain_start,
  input  logic [RC_W-1:0]        out_row,
  input  logic [RC_W-1:0]        out_col,
  input  logic [RC_W-1:0]        out_width,
  input  logic [ADDR_W-1:0]      chan_pixels,
  output logic                   drain_busy,
  output logic                   drain_valid,
  input  logic                   drain_ready,
  output logic [DATA_W-1:0]      drain_data,
  output logic [ADDR_W-1:0]      drain_addr
);
  localparam int BANK_W = $clog2(N_PE);
  localparam int IDX_W  = CO_W - BANK_W;

  logic [N_PE-1:0]   acc_valid;
  logic [N_PE-1:0]   bank_wr_en;
  logic [DATA_W-1:0] bank_rd [N_PE];
  logic [CO_W-1:0]   dr_co;
  logic              addr_load;

  generate
    for (genvar p = 0; p < N_PE; p++) begin : g_lane
      logic [CO_W-1:0] lane_co;
      logic            lane_owns;
      assign lane_co      = upd_co[p*CO_W +: CO_W];
      assign lane_owns    = (lane_co[BANK_W-1:0] == BANK_W'(p));
      assign acc_valid[p] = upd_valid[p] & lane_owns & ~drain_busy;

      oca_bank #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
      ) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (acc_valid[p]),
        .upd_idx    (lane_co[CO_W-1:BANK_W]),
        .upd_first  (upd_ci[p*CI_W +: CI_W] == '0),
        .upd_val    (upd_val[p*DATA_W +: DATA_W]),
        .drain_mode (drain_busy),
        .drain_idx  (dr_co[CO_W-1:BANK_W]),
        .rd_data    (bank_rd[p]),
        .wr_en      (bank_wr_en[p])
      );
    end
  endgenerate

  oca_drain #(
    .NUM_CO (NUM_CO),
    .CO_W   (CO_W)
  ) u_drain (
    .clk   (clk),
    .rst_n (rst_n),
    .start (drain_start),
    .ready (drain_ready),
    .busy  (drain_busy),
    .valid (drain_valid),
    .co    (dr_co)
  );

  assign addr_load = drain_start & ~drain_busy;

  oca_addr #(
    .RC_W   (RC_W),
    .ADDR_W (ADDR_W),
    .CO_W   (CO_W)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (addr_load),
    .row   (out_row),
    .col   (out_col),
    .width (out_width),
    .chpix (chan_pixels),
    .co    (dr_co),
    .addr  (drain_addr)
  );

  assign drain_data = bank_rd[dr_co[BANK_W-1:0]];

endmodule

// File: rtl/out_ch_accum_chk.sv
module out_ch_accum_chk #(
  parameter int N_PE   = 4,
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_PE-1:0]   upd_valid,
  input logic [N_PE-1:0]   acc_valid,
  input logic [N_PE-1:0]   wr_en,
  input logic              drain_start,
  input logic              drain_busy,
  input logic              drain_valid,
  input logic              drain_ready,
  input logic [DATA_W-1:0] drain_data,
  input logic [ADDR_W-1:0] drain_addr
);

  AST_WRITE_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en == $past(acc_valid, 2)); // R3

  AST_ONLY_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid & ~upd_valid) == '0); // R4

  AST_IGNORE_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    drain_busy |-> acc_valid == '0); // R9

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !drain_busy |-> !drain_valid); // R9

  AST_FIRST_BEAT_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_start && !drain_busy) |=> !drain_valid); // R9

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=>
      (drain_valid && $stable(drain_data) && $stable(drain_addr))); // R7

endmodule

bind out_ch_accum out_ch_accum_chk #(
  .N_PE   (N_PE),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .upd_valid   (upd_valid),
  .acc_valid   (acc_valid),
  .wr_en       (bank_wr_en),
  .drain_start (drain_start),
  .drain_busy  (drain_busy),
  .drain_valid (drain_valid),
  .drain_ready (drain_ready),
  .drain_data  (drain_data),
  .drain_addr  (drain_addr)
);

// File: tb/out_ch_accum_tb.sv
`timescale 1ns/1ps
module out_ch_accum_tb;
  localparam int NPE = 4;
  localparam int NCO = 16;
  localparam int DW  = 16;
  localparam int CIW = 4;
  localparam int RCW = 8;
  localparam int AW  = 16;
  localparam int COW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic               rst_n;
  logic [NPE-1:0]     upd_valid;
  logic [NPE*COW-1:0] upd_co;
  logic [NPE*CIW-1:0] upd_ci;
  logic [NPE*DW-1:0]  upd_val;
  logic               drain_start;
  logic [RCW-1:0]     out_row, out_col, out_width;
  logic [AW-1:0]      chan_pixels;
  logic               drain_busy, drain_valid, drain_ready;
  logic [DW-1:0]      drain_data;
  logic [AW-1:0]      drain_addr;

  out_ch_accum #(
    .N_PE(NPE), .NUM_CO(NCO), .DATA_W(DW), .CI_W(CIW), .RC_W(RCW), .ADDR_W(AW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_co(upd_co), .upd_ci(upd_ci), .upd_val(upd_val),
    .drain_start(drain_start), .out_row(out_row), .out_col(out_col),
    .out_width(out_width), .chan_pixels(chan_pixels),
    .drain_busy(drain_busy), .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_data(drain_data), .drain_addr(drain_addr)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [NCO];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic clear_lanes();
    upd_valid = '0;
    upd_co    = '0;
    upd_ci    = '0;
    upd_val   = '0;
  endtask

  // Drive one lane and fold the update into the model when the lane owns it.
  task automatic lane(input int p, input int co, input int ci, input int val, input bit v);
    upd_valid[p]           = v;
    upd_co[p*COW +: COW]   = COW'(co);
    upd_ci[p*CIW +: CIW]   = CIW'(ci);
    upd_val[p*DW +: DW]    = DW'(val);
    if (v && (co % NPE) == p)
      model[co] = (ci == 0) ? DW'(val) : DW'(model[co] + DW'(val));
  endtask

  task automatic step();
    @(negedge clk);
    clear_lanes();
  endtask

  task automatic run_drain(input int row, input int col, input int width, input int chpix,
                           input int mode, input bit inject, input string tag);
    int k;
    int cyc;
    bit held;
    logic [DW-1:0] sd;
    logic [AW-1:0] sa;
    logic [AW-1:0] ea;
    drain_start = 1'b1;
    out_row     = RCW'(row);
    out_col     = RCW'(col);
    out_width   = RCW'(width);
    chan_pixels = AW'(chpix);
    @(negedge clk);
    drain_start = 1'b0;
    out_row = '0; out_col = '0; out_width = '0; chan_pixels = '0;
    #1;
    chk(drain_busy && !drain_valid, "R9", "first cycle busy/valid",
        {drain_busy, drain_valid}, 2'b10);
    @(negedge clk);
    #1;
    chk(!drain_valid, "R9", "second cycle valid", drain_valid, 0);
    @(negedge clk);
    k = 0; cyc = 0; held = 1'b0; sd = '0; sa = '0;
    while (k < NCO && cyc < 2000) begin
      drain_ready = (mode == 0) ? 1'b1 : ((cyc % 3) != 1);
      if (inject && cyc == 1) begin
        upd_valid[0] = 1'b1; upd_co[COW-1:0] = '0; upd_ci[CIW-1:0] = '0;
        upd_val[DW-1:0] = DW'(1234);
      end
      if (inject && cyc == 2) clear_lanes();
      #1;
      if (held)
        chk(drain_valid && drain_data == sd && drain_addr == sa, "R7",
            "stalled beat held", {drain_data, drain_addr}, {sd, sa});
      held = 1'b0;
      if (drain_valid) begin
        if (drain_ready) begin
          ea = AW'(k * chpix + row * width + col);
          chk(drain_data == model[k], tag, $sformatf("sum ch %0d", k), drain_data, model[k]);
          chk(drain_addr == ea, "R8", $sformatf("addr ch %0d", k), drain_addr, ea);
          k++;
        end else begin
          held = 1'b1; sd = drain_data; sa = drain_addr;
        end
      end
      @(negedge clk);
      cyc++;
    end
    chk(k == NCO, "R7", "beats delivered", k, NCO);
    drain_ready = 1'b0;
    clear_lanes();
    @(negedge clk);
    #1;
    chk(!drain_busy && !drain_valid, "R7", "idle after last beat",
        {drain_busy, drain_valid}, 0);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL R7 watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    clear_lanes();
    drain_start = 1'b0; drain_ready = 1'b0;
    out_row = '0; out_col = '0; out_width = '0; chan_pixels = '0;
    for (int i = 0; i < NCO; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(!drain_busy && !drain_valid, "R1", "reset outputs", {drain_busy, drain_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Pixel A: three input channels, all lanes, then misrouted and invalid lanes (R3 R4).
    for (int ci = 0; ci < 3; ci++)
      for (int g = 0; g < NCO / NPE; g++) begin
        for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, ci, (g*NPE + p)*7 + ci*3 - 20, 1'b1);
        step();
      end
    lane(1, 4, 1, 999, 1'b1);
    lane(2, 6, 1, 500, 1'b0);
    lane(3, 2, 1, 77, 1'b1);
    step();
    repeat (4) step();
    run_drain(3, 4, 7, 35, 0, 1'b0, "R3 R4");

    // Pixel B: same channel in consecutive and alternating cycles, wrapping sums (R5 R6).
    for (int g = 0; g < NCO / NPE; g++) begin
      for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, 0, 'h7000, 1'b1);
      step();
    end
    for (int g = 0; g < NCO / NPE; g++)
      for (int r = 1; r <= 4; r++) begin
        for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, r, 'h3000, 1'b1);
        step();
      end
    for (int r = 1; r <= 4; r++)
      for (int g = 0; g < 2; g++) begin
        for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, r, r*5 + p - 9, 1'b1);
        step();
      end
    repeat (4) step();
    run_drain(0, 0, 7, 35, 1, 1'b0, "R5 R6");

    // Pixel C: overwrite from the previous pixel, wide address, update during drain (R2 R9).
    for (int g = 0; g < NCO / NPE; g++) begin
      for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, 0, 100 + g*NPE + p, 1'b1);
      step();
    end
    for (int g = NCO / NPE - 1; g >= 0; g--) begin
      for (int p = 0; p < NPE; p++) lane(p, g*NPE + p, 2, -(g*NPE + p), 1'b1);
      step();
    end
    repeat (4) step();
    run_drain(10, 20, 50, 5000, 0, 1'b1, "R2");
    run_drain(10, 20, 50, 5000, 1, 1'b0, "R9");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule